// File: doc/BRIEF.md
# Counterflow Systolic FIR Filter

This block is a finite impulse response filter built as a linear systolic array of identical multiply-accumulate cells. Each cell keeps one coefficient that stays in place while filtering runs. Input samples step through the array in one direction, one cell per clock. Partial sums step through it in the other direction at the same rate. A partial sum starts as zero at the far end of the array. Every cell it passes adds the product of that cell's coefficient and the sample the cell currently holds. The finished sum leaves at the same end where the samples enter.

The streams run in opposite directions, so a sample meets a given partial sum in only every other cell. A sample can therefore be taken in at most every second cycle. The control refuses a sample in the cycle after one has been taken. It also refuses samples in any cycle that loads a coefficient. Coefficients are loaded by shifting them in, one per cycle, while the load input is high. Each result appears a fixed two cycles after its sample, together with a valid flag. The flag is high only for results that belong to real samples.

Top module: `fir_counterflow`

## Requirements
- R1: In reset and in the first cycle after it, with no load and no sample offered, `resultValid` is 0, `resultOut` is 0 and `sampleReady` is 1. All coefficients reset to 0.
- R2: Let s(t) be the signed sample accepted in cycle t, or 0 if none was accepted. The result for a sample accepted in cycle t is the sum over j = 0..TAPS-1 of c_j·s(t−2j), in two's complement.
- R3: `resultValid` is high exactly two cycles after each accepted sample. It is never high otherwise, whatever the spacing between samples.
- R4: In the cycle after a sample is accepted, `sampleReady` is 0. A sample offered in that cycle is dropped: it produces no result and adds nothing to later sums.
- R5: While `coefLoad` is 1, `sampleReady` is 0 and any offered sample is dropped.
- R6: Each cycle with `coefLoad` high shifts `coefIn` into the coefficient chain. After TAPS load cycles, the first value loaded is c_0, which multiplies the newest sample, and the last value loaded is c_{TAPS-1}. Coefficients keep their values while `coefLoad` is 0.
- R7: `resultOut` is ACC_W = 2·DATA_W + ceil(log2 TAPS) bits wide. Results at the extremes of signed input and coefficient ranges do not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| coefLoad | input | 1 | Shift `coefIn` into the coefficient chain this cycle |
| coefIn | input | DATA_W | Signed coefficient to shift in |
| sampleValid | input | 1 | A sample is offered this cycle |
| sampleIn | input | DATA_W | Signed input sample |
| sampleReady | output | 1 | A sample offered this cycle will be accepted |
| resultValid | output | 1 | `resultOut` holds a finished result |
| resultOut | output | ACC_W | Signed filter result |

## Verification
The assertions assume that `coefLoad` and `sampleValid` carry known values after reset. The readiness and latency rules are written purely in terms of the accept handshake, so they hold whatever order the inputs arrive in. Result values are correct only when no coefficient changes while partial sums are still in the array. The stimulus therefore leaves at least 2·TAPS idle cycles before and after each load sequence. Between loads it offers samples back to back, with single gaps, and with wider gaps that move the sample phase.

// File: rtl/fir_cf_pkg.sv
package fir_cf_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic inject;     // a sample enters the first x stage this cycle
    logic loadShift;  // shift coefficient chain by one
  } strobe_t;

endpackage

// File: rtl/fir_cf_cell.sv
module fir_cf_cell #(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 18
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic signed [DATA_W-1:0] weight,
  input  logic signed [DATA_W-1:0] xHere,
  input  logic signed [ACC_W-1:0]  yIn,
  output logic signed [ACC_W-1:0]  yOut
);

  localparam int PROD_W = 2 * DATA_W;

  logic signed [PROD_W-1:0] prod;

  always_comb prod = weight * xHere;

  // Partial sum picks up this cell's product and moves one cell on
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) yOut <= '0;
    else       yOut <= yIn + ACC_W'(prod);
  end

endmodule

// File: rtl/fir_cf_ctrl.sv
module fir_cf_ctrl
  import fir_cf_pkg::*;
#(
  parameter int LATENCY = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    coefLoad,
  input  logic    sampleValid,
  output logic    sampleReady,
  output logic    resultValid,
  output strobe_t stb
);

  logic               lastTaken;
  logic               take;
  logic [LATENCY-1:0] validPipe;

  always_comb begin
    sampleReady   = !coefLoad && !lastTaken;
    take          = sampleValid && sampleReady;
    stb.inject    = take;
    stb.loadShift = coefLoad;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastTaken <= 1'b0;
    else       lastTaken <= take;
  end

  // Valid flag rides along with the bubble pattern
  generate
    if (LATENCY == 1) begin : gOneStage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) validPipe <= '0;
        else       validPipe <= take;
      end
    end else begin : gMultiStage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) validPipe <= '0;
        else       validPipe <= {validPipe[LATENCY-2:0], take};
      end
    end
  endgenerate

  assign resultValid = validPipe[LATENCY-1];

endmodule

// File: rtl/fir_cf_datapath.sv
module fir_cf_datapath
  import fir_cf_pkg::*;
#(
  parameter int TAPS   = 4,
  parameter int DATA_W = 8,
  parameter int ACC_W  = 18
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  stb,
  input  logic signed [DATA_W-1:0] coefIn,
  input  logic signed [DATA_W-1:0] sampleIn,
  output logic signed [ACC_W-1:0]  resultOut
);

  logic signed [DATA_W-1:0] xLine  [TAPS];
  logic signed [DATA_W-1:0] wLine  [TAPS];
  logic signed [ACC_W-1:0]  yChain [TAPS+1];

  // Sample stage of cell 0: a bubble carries zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           xLine[0] <= '0;
    else if (stb.inject) xLine[0] <= sampleIn;
    else                 xLine[0] <= '0;
  end

  // Coefficient entry at the far cell
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              wLine[TAPS-1] <= '0;
    else if (stb.loadShift) wLine[TAPS-1] <= coefIn;
  end

  generate
    for (genvar j = 1; j < TAPS; j++) begin : gXStage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) xLine[j] <= '0;
        else       xLine[j] <= xLine[j-1];
      end
    end

    for (genvar j = 0; j < TAPS - 1; j++) begin : gWStage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              wLine[j] <= '0;
        else if (stb.loadShift) wLine[j] <= wLine[j+1];
      end
    end

    for (genvar j = 0; j < TAPS; j++) begin : gCell
      fir_cf_cell #(
        .DATA_W(DATA_W),
        .ACC_W (ACC_W)
      ) uCell (
        .clk   (clk),
        .rstN  (rstN),
        .weight(wLine[j]),
        .xHere (xLine[j]),
        .yIn   (yChain[j+1]),
        .yOut  (yChain[j])
      );
    end
  endgenerate

  // Partial sums start empty at the far end
  assign yChain[TAPS] = '0;
  assign resultOut    = yChain[0];

endmodule

// File: rtl/fir_counterflow.sv
module fir_counterflow
  import fir_cf_pkg::*;
#(
  parameter int TAPS   = 4,
  parameter int DATA_W = 8,
  parameter int ACC_W  = 2 * DATA_W + $clog2(TAPS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              coefLoad,
  input  logic [DATA_W-1:0] coefIn,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              sampleReady,
  output logic              resultValid,
  output logic [ACC_W-1:0]  resultOut
);

  localparam int LATENCY = 2;

  strobe_t                  stb;
  logic signed [ACC_W-1:0]  sumOut;

  fir_cf_ctrl #(
    .LATENCY(LATENCY)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .coefLoad   (coefLoad),
    .sampleValid(sampleValid),
    .sampleReady(sampleReady),
    .resultValid(resultValid),
    .stb        (stb)
  );

  fir_cf_datapath #(
    .TAPS  (TAPS),
    .DATA_W(DATA_W),
    .ACC_W (ACC_W)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .coefIn   (coefIn),
    .sampleIn (sampleIn),
    .resultOut(sumOut)
  );

  assign resultOut = sumOut;

endmodule

// File: rtl/fir_counterflow_chk.sv
module fir_counterflow_chk (
  input logic clk,
  input logic rstN,
  input logic coefLoad,
  input logic sampleValid,
  input logic sampleReady,
  input logic resultValid
);

  AST_GAP_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && sampleReady) |=> !sampleReady); // R4

  AST_LOAD_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    coefLoad |-> !sampleReady); // R5

  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && sampleReady) |=> ##1 resultValid); // R3

  AST_RESULT_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> $past(sampleValid && sampleReady, 2)); // R3

  AST_NO_RESULT_BURST: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid); // R4

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
    $rose(rstN) |-> !resultValid); // R1

endmodule

bind fir_counterflow fir_counterflow_chk uChk (
  .clk        (clk),
  .rstN       (rstN),
  .coefLoad   (coefLoad),
  .sampleValid(sampleValid),
  .sampleReady(sampleReady),
  .resultValid(resultValid)
);

// File: tb/sim_fir_counterflow.sv
module sim_fir_counterflow;

  localparam int TAPS   = 4;
  localparam int DATA_W = 8;
  localparam int ACC_W  = 2 * DATA_W + $clog2(TAPS);
  localparam int HIST   = 2 * TAPS;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              coefLoad = 1'b0;
  logic [DATA_W-1:0] coefIn = '0;
  logic              sampleValid = 1'b0;
  logic [DATA_W-1:0] sampleIn = '0;
  logic              sampleReady;
  logic              resultValid;
  logic [ACC_W-1:0]  resultOut;

  int compared = 0;
  int mismatched = 0;
  int seed = 12345;
  string curTag = "R2";

  // behavioural model state
  int  mw [TAPS];
  int  hist [HIST];
  bit  expV [2];
  int  expD [2];
  bit  prevTaken;

  always #2 clk = ~clk;

  fir_counterflow #(.TAPS(TAPS), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rstN(rstN), .coefLoad(coefLoad), .coefIn(coefIn),
    .sampleValid(sampleValid), .sampleIn(sampleIn),
    .sampleReady(sampleReady), .resultValid(resultValid), .resultOut(resultOut)
  );

  function automatic int nextRand(input int lo, input int hi);
    seed = seed * 1103515245 + 12345;
    return lo + ((seed >>> 8) & 32'h7fff) % (hi - lo + 1);
  endfunction

  task automatic step(input bit ld, input int coef, input bit vld, input int smp);
    bit expRdy;
    bit taken;
    int sum;
    @(negedge clk);
    compared++;
    if (resultValid !== expV[1]) begin
      mismatched++;
      $display("FAIL %s/R3 resultValid act=%0b exp=%0b", curTag, resultValid, expV[1]);
    end else if (expV[1]) begin
      compared++;
      if ($signed(resultOut) !== expD[1]) begin
        mismatched++;
        $display("FAIL %s resultOut act=%0d exp=%0d", curTag, $signed(resultOut), expD[1]);
      end
    end
    coefLoad    = ld;
    coefIn      = DATA_W'(coef);
    sampleValid = vld;
    sampleIn    = DATA_W'(smp);
    #1;
    expRdy = !ld && !prevTaken;
    compared++;
    if (sampleReady !== expRdy) begin
      mismatched++;
      $display("FAIL %s sampleReady act=%0b exp=%0b", ld ? "R5" : "R4", sampleReady, expRdy);
    end
    taken = vld && expRdy;
    for (int k = HIST - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = taken ? smp : 0;
    sum = 0;
    for (int j = 0; j < TAPS; j++) sum += mw[j] * hist[2*j];
    if (ld) begin
      for (int j = 0; j < TAPS - 1; j++) mw[j] = mw[j+1];
      mw[TAPS-1] = coef;
    end
    expV[1] = expV[0]; expD[1] = expD[0];
    expV[0] = taken;   expD[0] = sum;
    prevTaken = taken;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 1'b0, 0);
  endtask

  task automatic loadAll(input int c0, input int c1, input int c2, input int c3);
    // R5: a sample offered during load must be dropped
    step(1'b1, c0, 1'b1, 77);
    step(1'b1, c1, 1'b0, 0);
    step(1'b1, c2, 1'b1, -9);
    step(1'b1, c3, 1'b0, 0);
  endtask

  initial begin
    for (int j = 0; j < TAPS; j++) mw[j] = 0;
    for (int k = 0; k < HIST; k++) hist[k] = 0;
    expV[0] = 0; expV[1] = 0; expD[0] = 0; expD[1] = 0;
    prevTaken = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    compared++;
    if (resultValid !== 1'b0 || resultOut !== '0 || sampleReady !== 1'b1) begin
      mismatched++;
      $display("FAIL R1 reset act=%0b/%0d/%0b exp=0/0/1", resultValid, resultOut, sampleReady);
    end

    // R1: zero coefficients give zero results
    curTag = "R1";
    step(1'b0, 0, 1'b1, 55); idle(4);

    // R6: impulse reveals coefficient order
    curTag = "R6";
    idle(HIST); loadAll(1, 2, 3, 4); idle(HIST + 2);
    step(1'b0, 0, 1'b1, 1);
    for (int i = 0; i < TAPS + 1; i++) begin step(1'b0, 0, 1'b0, 0); step(1'b0, 0, 1'b1, 0); end
    idle(HIST);

    // R2: single-gap stream of signed samples
    curTag = "R2";
    for (int i = 0; i < 30; i++) begin
      step(1'b0, 0, 1'b1, nextRand(-128, 127)); step(1'b0, 0, 1'b0, 0);
    end
    idle(HIST);

    // R4: back-to-back offers, every second one dropped
    curTag = "R4";
    for (int i = 0; i < 24; i++) step(1'b0, 0, 1'b1, nextRand(-128, 127));
    idle(HIST);

    // R3: irregular spacing shifts phase, latency stays fixed
    curTag = "R3";
    idle(HIST); loadAll(-3, 7, -128, 127); idle(HIST + 2);
    for (int i = 0; i < 40; i++) begin
      step(1'b0, 0, 1'b1, nextRand(-128, 127));
      idle(nextRand(1, 3));
    end
    idle(HIST);

    // R7: extremes do not wrap
    curTag = "R7";
    loadAll(-128, -128, -128, -128); idle(HIST + 2);
    for (int i = 0; i < 8; i++) begin step(1'b0, 0, 1'b1, -128); step(1'b0, 0, 1'b0, 0); end
    for (int i = 0; i < 8; i++) begin step(1'b0, 0, 1'b1, 127); step(1'b0, 0, 1'b0, 0); end
    idle(HIST);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 4);
    mismatched++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule